// File: doc/BRIEF.md
# Multi-Line Transmit Scan Dispatcher

This block serves the transmit side of a group of serial lines. It watches one ready flag for each line's transmitter and checks them in turn. The search starts just after the line it served last. For the first line that is ready and still has characters queued, it reads that line's next character from shared memory, using a buffer pointer held for that line. It then adds the character code to a fixed control-table base and reads a second byte, the control byte. A suppress bit in that byte decides the outcome. Either the character is handed to the line's transmitter with a one-cycle load strobe, or it is dropped without a load.

Each line's buffer pointer and remaining byte count live in a small register file inside the block. Each service step moves the pointer forward by one and lowers the count by one. When the count reaches zero, the line raises its finished flag and is no longer served. Host software sets up a line by writing its pointer and its count through a line-select and field-select write port. Writing a count clears that line's finished flag.

Memory is reached through a simple request/grant port, and every service needs two reads. The serializers and the memory are not part of this block.

Top module: `txd_dispatch`

## Requirements
- R1: After reset no load strobe and no memory request is active, every finished flag is 0 and every byte count is 0, so no line is served even when its ready flag is 1.
- R2: A line is served only while its ready flag is 1 and its byte count is non-zero. A line that is not ready, or whose count is 0, gets no load strobe.
- R3: The search for the next line starts at the line after the one served last, wrapping from the highest index to 0, and begins at line 0 after reset. When every line stays eligible, the load strobes visit the lines in ascending cyclic order.
- R4: The first read of a service uses the line's current pointer, and the byte returned is the character presented on `tx_char` with the load strobe.
- R5: The second read of a service uses the address `CTRL_BASE` plus the character code, zero-extended to the address width.
- R6: Bit 0 of the control byte is the suppress bit, and bits 7 to 1 are ignored. With suppress set, no load strobe is given, but the pointer and the count still advance.
- R7: Every service, loaded or suppressed, adds 1 to the line's pointer and subtracts 1 from its count. When the count goes from 1 to 0, the line's finished flag rises, and a line whose flag is set is never loaded.
- R8: A host write with `host_field` 0 sets the selected line's pointer. A write with `host_field` 1 sets its count and clears its finished flag. A pointer write leaves the flag unchanged. A host write to a field takes precedence over a service update to that field in the same cycle.
- R9: Once raised, `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_gnt` is 1. `mem_rdata` is taken in that same cycle.
- R10: `tx_load` has at most one bit set and is never high in two consecutive cycles. `tx_char` is valid in the cycle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ready | input | N_LINES | Ready flag of each line's transmitter |
| tx_load | output | N_LINES | One-cycle load strobe to the selected transmitter |
| tx_char | output | 8 | Character being loaded |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_gnt | input | 1 | Grant; the read data is valid in this cycle |
| mem_rdata | input | 8 | Memory read data |
| host_we | input | 1 | Host write strobe for the per-line table |
| host_line | input | LINE_W | Line selected by the host write |
| host_field | input | 1 | 0 selects the pointer, 1 selects the count |
| host_wdata | input | ADDR_W | Host write value |
| line_done | output | N_LINES | Per-line finished flag |

## Verification
A wrong pointer in the register file appears as a wrong character on `tx_char` at that line's next load strobe. A wrong control-table address appears at the second read of the same service, which comes within two grants. A count that is off by one shows as a finished flag that rises one service early or late, or as an extra strobe on a finished line. Harm to the round-robin start index breaks the ascending load order within one pass over the lines. A stuck sequencer shows as a request that drops before its grant, or as a strobe that lasts two cycles.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int CODE_W       = 8;
    localparam int SUPPRESS_BIT = 0;

    typedef enum logic [1:0] {
        ST_SCAN     = 2'd0,
        ST_GET_CHAR = 2'd1,
        ST_GET_CTRL = 2'd2,
        ST_ISSUE    = 2'd3
    } svc_state_e;

    typedef enum logic {
        FLD_PTR  = 1'b0,
        FLD_LEFT = 1'b1
    } line_field_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              suppress;
    } svc_word_t;

    function automatic int wrap_next(input int cur, input int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

    function automatic int index_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/txd_line_ram.sv
module txd_line_ram
    import txd_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LINE_W-1:0]  wr_line,
    input  line_field_e        wr_field,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic               adv_en,
    input  logic [LINE_W-1:0]  adv_line,
    input  logic [LINE_W-1:0]  rd_line,
    output logic [ADDR_W-1:0]  rd_ptr,
    output logic [N_LINES-1:0] live,
    output logic [N_LINES-1:0] done
);

    logic [ADDR_W-1:0] ptr_all [N_LINES];

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic              wr_hit;
        logic              adv_hit;
        logic [ADDR_W-1:0] ptr_r;
        logic [ADDR_W-1:0] left_r;
        logic              done_r;

        assign wr_hit  = wr_en  && (wr_line  == LINE_W'(i));
        assign adv_hit = adv_en && (adv_line == LINE_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_r  <= '0;
                left_r <= '0;
                done_r <= 1'b0;
            end else begin
                if (wr_hit && wr_field == FLD_PTR) begin
                    ptr_r <= wr_data;
                end else if (adv_hit) begin
                    ptr_r <= ptr_r + 1'b1;
                end

                if (wr_hit && wr_field == FLD_LEFT) begin
                    left_r <= wr_data;
                    done_r <= 1'b0;
                end else if (adv_hit && left_r != '0) begin
                    left_r <= left_r - 1'b1;
                    if (left_r == ADDR_W'(1)) begin
                        done_r <= 1'b1;
                    end
                end
            end
        end

        assign ptr_all[i] = ptr_r;
        assign live[i]    = (left_r != '0);
        assign done[i]    = done_r;
    end

    assign rd_ptr = ptr_all[rd_line];

    AST_DONE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (done & live) == '0);  // R7

    AST_COUNT_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_field == FLD_LEFT) |=> !done[$past(wr_line)]);  // R8

endmodule

// File: rtl/txd_rr_pick.sv
module txd_rr_pick
    import txd_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int LINE_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] req,
    input  logic [LINE_W-1:0]  start,
    output logic               found,
    output logic [LINE_W-1:0]  pick
);

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N_LINES; k++) begin
            int idx;
            idx = int'(start) + k;
            if (idx >= N_LINES) begin
                idx = idx - N_LINES;
            end
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = LINE_W'(idx);
            end
        end
    end

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        found |-> req[pick]);  // R2

    AST_PICK_START_FIRST: assert property (@(posedge clk) disable iff (rst)
        req[start] |-> (found && pick == start));  // R3

    AST_PICK_NONE: assert property (@(posedge clk) disable iff (rst)
        !found |-> (req == '0));  // R2

endmodule

// File: rtl/txd_svc_seq.sv
module txd_svc_seq
    import txd_pkg::*;
#(
    parameter int              N_LINES   = 16,
    parameter int              ADDR_W    = 16,
    parameter int              LINE_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 'hFF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pick_found,
    input  logic [LINE_W-1:0] pick_line,
    output logic [LINE_W-1:0] scan_start,
    output logic [LINE_W-1:0] cur_line,
    input  logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [CODE_W-1:0] mem_rdata,
    output logic              adv_en,
    output logic              load_en,
    output logic [CODE_W-1:0] load_code
);

    localparam int PAD_W = ADDR_W - CODE_W;

    svc_state_e        state_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] start_q;
    svc_word_t         word_q;
    logic [ADDR_W-1:0] ctrl_addr;

    assign ctrl_addr = CTRL_BASE + {{PAD_W{1'b0}}, word_q.code};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SCAN;
            line_q  <= '0;
            start_q <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_SCAN: begin
                    if (pick_found) begin
                        line_q  <= pick_line;
                        state_q <= ST_GET_CHAR;
                    end
                end
                ST_GET_CHAR: begin
                    if (mem_gnt) begin
                        word_q.code <= mem_rdata;
                        state_q     <= ST_GET_CTRL;
                    end
                end
                ST_GET_CTRL: begin
                    if (mem_gnt) begin
                        word_q.suppress <= mem_rdata[SUPPRESS_BIT];
                        state_q         <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    start_q <= LINE_W'(wrap_next(int'(line_q), N_LINES));
                    state_q <= ST_SCAN;
                end
                default: state_q <= ST_SCAN;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state_q == ST_GET_CHAR) || (state_q == ST_GET_CTRL);
        mem_addr = (state_q == ST_GET_CTRL) ? ctrl_addr : cur_ptr;
    end

    assign scan_start = start_q;
    assign cur_line   = line_q;
    assign adv_en     = (state_q == ST_ISSUE);
    assign load_en    = (state_q == ST_ISSUE) && !word_q.suppress;
    assign load_code  = word_q.code;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));  // R9

    AST_CTRL_ADDR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GET_CHAR && mem_gnt) |=>
            (mem_req && mem_addr == CTRL_BASE + {{PAD_W{1'b0}}, $past(mem_rdata)}));  // R5

    AST_ADVANCE_ONCE: assert property (@(posedge clk) disable iff (rst)
        adv_en |=> !adv_en);  // R7

endmodule

// File: rtl/txd_dispatch.sv
module txd_dispatch
    import txd_pkg::*;
#(
    parameter int                N_LINES   = 16,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 'hFF00,
    localparam int               LINE_W    = index_width(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] tx_ready,
    output logic [N_LINES-1:0] tx_load,
    output logic [CODE_W-1:0]  tx_char,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_gnt,
    input  logic [CODE_W-1:0]  mem_rdata,
    input  logic               host_we,
    input  logic [LINE_W-1:0]  host_line,
    input  logic               host_field,
    input  logic [ADDR_W-1:0]  host_wdata,
    output logic [N_LINES-1:0] line_done
);

    logic [N_LINES-1:0] live;
    logic [N_LINES-1:0] eligible;
    logic               pick_found;
    logic [LINE_W-1:0]  pick_line;
    logic [LINE_W-1:0]  scan_start;
    logic [LINE_W-1:0]  cur_line;
    logic [ADDR_W-1:0]  cur_ptr;
    logic               adv_en;
    logic               load_en;
    line_field_e        wr_field;

    assign eligible = tx_ready & live;
    assign wr_field = line_field_e'(host_field);

    txd_line_ram #(
        .N_LINES (N_LINES),
        .ADDR_W  (ADDR_W),
        .LINE_W  (LINE_W)
    ) u_ram (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_we),
        .wr_line  (host_line),
        .wr_field (wr_field),
        .wr_data  (host_wdata),
        .adv_en   (adv_en),
        .adv_line (cur_line),
        .rd_line  (cur_line),
        .rd_ptr   (cur_ptr),
        .live     (live),
        .done     (line_done)
    );

    txd_rr_pick #(
        .N_LINES (N_LINES),
        .LINE_W  (LINE_W)
    ) u_pick (
        .clk   (clk),
        .rst   (rst),
        .req   (eligible),
        .start (scan_start),
        .found (pick_found),
        .pick  (pick_line)
    );

    txd_svc_seq #(
        .N_LINES   (N_LINES),
        .ADDR_W    (ADDR_W),
        .LINE_W    (LINE_W),
        .CTRL_BASE (CTRL_BASE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pick_found (pick_found),
        .pick_line  (pick_line),
        .scan_start (scan_start),
        .cur_line   (cur_line),
        .cur_ptr    (cur_ptr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .adv_en     (adv_en),
        .load_en    (load_en),
        .load_code  (tx_char)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_strobe
        assign tx_load[i] = load_en && (cur_line == LINE_W'(i));
    end

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_load));  // R10

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (tx_load != '0) |=> (tx_load == '0));  // R10

    AST_NO_LOAD_FINISHED: assert property (@(posedge clk) disable iff (rst)
        (tx_load & line_done) == '0);  // R7

endmodule

// File: tb/sim_txd_dispatch.sv
module sim_txd_dispatch;

    localparam int NL = 16;
    localparam logic [15:0] CBASE = 16'hFF00;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] tx_ready;
    logic [NL-1:0] tx_load;
    logic [7:0]    tx_char;
    logic          mem_req;
    logic [15:0]   mem_addr;
    logic          mem_gnt;
    logic [7:0]    mem_rdata;
    logic          host_we = 1'b0;
    logic [3:0]    host_line = '0;
    logic          host_field = 1'b0;
    logic [15:0]   host_wdata = '0;
    logic [NL-1:0] line_done;

    always #4 clk = ~clk;

    txd_dispatch #(.N_LINES(NL), .ADDR_W(16), .CTRL_BASE(CBASE)) u0 (
        .clk(clk), .rst(rst), .tx_ready(tx_ready), .tx_load(tx_load), .tx_char(tx_char),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .host_we(host_we), .host_line(host_line), .host_field(host_field),
        .host_wdata(host_wdata), .line_done(line_done)
    );

    int checks = 0;
    int fails  = 0;

    logic [NL-1:0] ready_mask = '0;
    bit            always_ready = 1'b1;
    bit            sup_en = 1'b0;
    bit            order_mode = 1'b0;
    int            order_idx = 0;
    int            gnt_max = 0;
    int            busy [NL];
    int            loads_seen [NL];
    logic [15:0]   m_ptr [NL];
    logic [15:0]   m_cnt [NL];

    function automatic logic [7:0] dfn(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd37 + (a >> 5);
        return t[7:0] ^ t[15:8];
    endfunction

    function automatic bit is_sup(input logic [7:0] c);
        return sup_en && (c % 3 == 0);
    endfunction

    function automatic logic [7:0] ctrlfn(input logic [7:0] c);
        return {c[6:0] ^ 7'h35, is_sup(c)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory model: random grant delay, checks request hold and control address
    int          wait_cnt = 0;
    bit          phase = 1'b0;
    bit          pend = 1'b0;
    logic [15:0] pend_addr = '0;
    logic [7:0]  last_char = '0;
    initial begin
        mem_gnt = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (pend) check(mem_req && mem_addr == pend_addr, "R9 hold", int'(mem_addr), int'(pend_addr));
            mem_gnt = 1'b0;
            pend = 1'b0;
            if (rst) begin
                phase = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    mem_gnt = 1'b1;
                    if (mem_addr[15:8] == 8'hFF) mem_rdata = ctrlfn(mem_addr[7:0]);
                    else                         mem_rdata = dfn(mem_addr);
                    if (!phase) last_char = mem_rdata;
                    else check(mem_addr == CBASE + {8'h00, last_char}, "R5 ctrl address",
                               int'(mem_addr), int'(CBASE + {8'h00, last_char}));
                    phase = ~phase;
                    wait_cnt = $urandom_range(0, gnt_max);
                end else begin
                    wait_cnt--;
                    pend = 1'b1;
                    pend_addr = mem_addr;
                end
            end
        end
    end

    // transmitter model and load checker
    bit prev_load = 1'b0;
    initial begin
        tx_ready = '0;
        for (int i = 0; i < NL; i++) begin busy[i] = 0; loads_seen[i] = 0; end
        forever begin
            @(negedge clk);
            for (int i = 0; i < NL; i++) if (busy[i] > 0) busy[i]--;
            if (!rst) begin
                if (prev_load) check(tx_load == '0, "R10 single-cycle strobe", int'(tx_load), 0);
                prev_load = (tx_load != '0);
                if (tx_load != '0) begin
                    int ln;
                    ln = 0;
                    check($onehot(tx_load), "R10 one-hot strobe", int'(tx_load), 0);
                    for (int i = 0; i < NL; i++) if (tx_load[i]) ln = i;
                    loads_seen[ln]++;
                    while (m_cnt[ln] != 0 && is_sup(dfn(m_ptr[ln]))) begin
                        m_ptr[ln]++;
                        m_cnt[ln]--;
                    end
                    if (m_cnt[ln] == 0) begin
                        check(1'b0, "R2 load on line with nothing pending", ln, -1);
                    end else begin
                        check(tx_char == dfn(m_ptr[ln]), "R4 loaded character",
                              int'(tx_char), int'(dfn(m_ptr[ln])));
                        m_ptr[ln]++;
                        m_cnt[ln]--;
                    end
                    if (order_mode) begin
                        check(ln == order_idx % NL, "R3 round-robin order", ln, order_idx % NL);
                        order_idx++;
                    end
                    busy[ln] = always_ready ? 0 : int'($urandom_range(1, 4));
                end
            end
            for (int i = 0; i < NL; i++) tx_ready[i] = ready_mask[i] && busy[i] == 0;
        end
    end

    task automatic hwrite(input int ln, input bit fld, input logic [15:0] v);
        @(negedge clk);
        host_we = 1'b1;
        host_line = 4'(ln);
        host_field = fld;
        host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        if (fld) m_cnt[ln] = v; else m_ptr[ln] = v;
    endtask

    task automatic wait_done(input logic [NL-1:0] exp, input string req);
        int n;
        n = 0;
        while (line_done != exp && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (8) @(negedge clk);
        check(line_done == exp, req, int'(line_done), int'(exp));
    endtask

    task automatic main_seq();
        logic [NL-1:0] exp_done;
        int            want;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_load == '0, "R1 no strobe after reset", int'(tx_load), 0);
        check(mem_req == 1'b0, "R1 no request after reset", int'(mem_req), 0);
        check(line_done == '0, "R1 finished flags clear", int'(line_done), 0);
        for (int i = 0; i < NL; i++) begin m_ptr[i] = '0; m_cnt[i] = '0; end

        // R1/R2: all ready but every count zero
        ready_mask = '1;
        want = 0;
        repeat (20) begin @(negedge clk); if (mem_req) want++; end
        check(want == 0, "R1 zero counts give no service", want, 0);
        ready_mask = '0;

        // R3/R4/R6: ordered pass, no suppress, junk in control upper bits
        gnt_max = 2;
        for (int i = 0; i < NL; i++) begin
            hwrite(i, 1'b0, 16'h0100 + 16'(i * 40));
            hwrite(i, 1'b1, 16'd2);
        end
        order_mode = 1'b1;
        order_idx = 0;
        always_ready = 1'b1;
        ready_mask = '1;
        wait_done('1, "R7 finished flags after ordered pass");
        check(order_idx == 2 * NL, "R3 loads in ordered pass", order_idx, 2 * NL);
        check(mem_req == 1'b0, "R7 finished lines not served", int'(mem_req), 0);
        order_mode = 1'b0;
        ready_mask = '0;

        // R8: pointer write keeps flag, count write clears it
        hwrite(3, 1'b0, 16'h2000);
        @(negedge clk);
        check(line_done[3] == 1'b1, "R8 pointer write keeps finished flag", int'(line_done[3]), 1);
        hwrite(3, 1'b1, 16'd1);
        check(line_done[3] == 1'b0, "R8 count write clears finished flag", int'(line_done[3]), 0);
        hwrite(5, 1'b0, 16'h3000);
        hwrite(5, 1'b1, 16'd3);
        for (int i = 0; i < NL; i++) loads_seen[i] = 0;
        ready_mask = 16'h0020;
        wait_done(16'hFFF7, "R2 only ready line finishes");
        check(loads_seen[3] == 0, "R2 not-ready line gets no strobe", loads_seen[3], 0);
        check(loads_seen[5] == 3, "R7 count limits loads", loads_seen[5], 3);
        ready_mask = 16'h0008;
        wait_done('1, "R8 reloaded line served again");
        check(loads_seen[3] == 1, "R8 reload count of one", loads_seen[3], 1);
        ready_mask = '0;

        // random rounds with suppression, busy transmitters, grant delays
        sup_en = 1'b1;
        always_ready = 1'b0;
        gnt_max = 3;
        for (int r = 0; r < 4; r++) begin
            exp_done = '0;
            for (int i = 0; i < NL; i++) begin
                logic [15:0] c;
                c = 16'($urandom_range(0, 7));
                hwrite(i, 1'b0, 16'($urandom_range(0, 16'hE000)));
                hwrite(i, 1'b1, c);
                exp_done[i] = (c != 0);
            end
            ready_mask = '1;
            wait_done(exp_done, "R7 random round finished flags");
            for (int i = 0; i < NL; i++) begin
                while (m_cnt[i] != 0 && is_sup(dfn(m_ptr[i]))) begin
                    m_ptr[i]++;
                    m_cnt[i]--;
                end
                check(m_cnt[i] == 0, "R6 suppressed characters consumed", int'(m_cnt[i]), 0);
            end
            ready_mask = '0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule